// File: doc/BRIEF.md
# Program Flow Sequencer with Interrupt Entry

This block owns the program counter, the return-address stack and the interrupt-enable state of a small 8-bit soft processor. Each clock cycle it takes one decoded flow command together with a target address and the current carry and zero flags, and it works out the next program counter. Jumps, calls and returns can be unconditional, or they can test a single carry or zero condition. Calls push the current address, and returns resume one past the stacked address.

An interrupt request is accepted only while interrupt entry is enabled. When it is accepted, the command presented in that cycle is dropped. Its address is pushed, the carry and zero flags are preserved, further interrupts are blocked, control moves to the all-ones vector and an acknowledge pulse is raised. The interrupt return resumes at the stacked address itself. It asks the flag logic to reload the preserved carry and zero, and it sets or clears interrupt entry according to an operand bit. Decode, the ALU, the register file and the instruction store sit outside this block.

Top module: `flow_seq`

## Requirements
- R1: Command code 1 (jump) with `cond_en`=0 loads `pc` with `target` on the next clock edge.
- R2: With `cond_en`=1, a jump, call or return tests `cond_sel` (0: C=1, 1: C=0, 2: Z=1, 3: Z=0 on `flag_c`/`flag_z`). A failed test, and command codes 0 and 7, advance `pc` by one (modulo 2^PC_W) and leave `tos` unchanged.
- R3: A taken call (code 2) advances `tos` by one, stores the current `pc` in the new top entry (seen on `stack_top`), and loads `pc` with `target`.
- R4: A taken return (code 3) loads `pc` with `stack_top` plus one and moves `tos` back by one.
- R5: An interrupt return (code 4) loads `pc` with `stack_top` unchanged, moves `tos` back by one, and raises `flag_restore` for exactly one cycle while `restore_c`/`restore_z` show the preserved flags.
- R6: An interrupt return sets `int_en` to the value of `reti_ie`.
- R7: Code 5 sets `int_en` and code 6 clears it. Both advance `pc` by one and leave `tos`, the stack and the preserved flags unchanged.
- R8: When `irq`=1 and `int_en`=1, the command is dropped. The current `pc` is pushed, `flag_c`/`flag_z` are copied to `restore_c`/`restore_z`, `int_en` is cleared, `pc` becomes all ones, and `irq_ack` is high for exactly one cycle.
- R9: The stack holds 31 entries. `tos` steps up from 30 to 0 and down from 0 to 30 with no error indication.
- R10: Synchronous reset drives `pc`, `tos`, `int_en`, `restore_c`, `restore_z`, `irq_ack` and `flag_restore` to zero.
- R11: While `int_en`=0, `irq` has no effect and the presented command executes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Flow command code |
| cond_en | input | 1 | Make jump/call/return conditional |
| cond_sel | input | 2 | Condition select |
| target | input | 10 | Jump/call target address |
| reti_ie | input | 1 | Interrupt-enable value after interrupt return |
| flag_c | input | 1 | Current carry flag |
| flag_z | input | 1 | Current zero flag |
| irq | input | 1 | Interrupt request |
| pc | output | 10 | Program counter |
| tos | output | 5 | Top-of-stack pointer |
| stack_top | output | 10 | Stack entry addressed by `tos` |
| int_en | output | 1 | Interrupt-enable flag |
| irq_ack | output | 1 | Interrupt taken (one-cycle pulse) |
| flag_restore | output | 1 | Reload carry/zero from preserved copies (pulse) |
| restore_c | output | 1 | Preserved carry |
| restore_z | output | 1 | Preserved zero |

## Verification
Each of the four conditions is applied with its flag both set and clear. This separates a wrong condition polarity from a swapped carry/zero selection. Nested calls followed by plain and interrupt returns tell apart the plus-one and the exact resume address. A run of 33 pushes and 34 pops shows whether the pointer wraps at 31 entries rather than at a power of two. Interrupt requests are raised with entry disabled and then enabled, with the flags changed before the return so that stale preserved copies are caught. A long random mix follows, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic [2:0] {
    OP_NEXT = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4,
    OP_IEN  = 3'd5,
    OP_IDIS = 3'd6,
    OP_NOP7 = 3'd7
  } flow_op_e;

  typedef enum logic [1:0] {
    CND_C  = 2'd0,
    CND_NC = 2'd1,
    CND_Z  = 2'd2,
    CND_NZ = 2'd3
  } flow_cond_e;
endpackage

// File: rtl/flow_cond.sv
module flow_cond
  import flow_pkg::*;
(
  input  logic       cond_en,
  input  logic [1:0] cond_sel,
  input  logic       flag_c,
  input  logic       flag_z,
  output logic       pass
);
  always_comb begin
    if (!cond_en) begin
      pass = 1'b1;
    end else begin
      unique case (flow_cond_e'(cond_sel))
        CND_C:   pass = flag_c;
        CND_NC:  pass = ~flag_c;
        CND_Z:   pass = flag_z;
        CND_NZ:  pass = ~flag_z;
        default: pass = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/flow_stack.sv
module flow_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 31,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [PW-1:0] ptr,
  output logic [W-1:0]  top
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr_up;
  logic [PW-1:0] ptr_dn;

  assign ptr_up = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign ptr_dn = (ptr == '0) ? LAST : ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (push) begin
      ptr <= ptr_up;
    end else if (pop) begin
      ptr <= ptr_dn;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !rst) begin
      mem[ptr_up] <= wdata;
    end
  end

  assign top = mem[ptr];
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int DEPTH = 31,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      op,
  input  logic            cond_en,
  input  logic [1:0]      cond_sel,
  input  logic [PC_W-1:0] target,
  input  logic            reti_ie,
  input  logic            flag_c,
  input  logic            flag_z,
  input  logic            irq,
  output logic [PC_W-1:0] pc,
  output logic [PW-1:0]   tos,
  output logic [PC_W-1:0] stack_top,
  output logic            int_en,
  output logic            irq_ack,
  output logic            flag_restore,
  output logic            restore_c,
  output logic            restore_z
);
  localparam logic [PC_W-1:0] VECTOR = '1;

  logic            pass;
  logic            take_irq;
  logic            push;
  logic            pop;
  logic [PC_W-1:0] pc_nxt;
  logic            ie_nxt;
  logic            restore_nxt;

  flow_cond u_cond (
    .cond_en  (cond_en),
    .cond_sel (cond_sel),
    .flag_c   (flag_c),
    .flag_z   (flag_z),
    .pass     (pass)
  );

  flow_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .pop   (pop),
    .wdata (pc),
    .ptr   (tos),
    .top   (stack_top)
  );

  assign take_irq = irq && int_en;

  always_comb begin
    push        = 1'b0;
    pop         = 1'b0;
    pc_nxt      = pc + 1'b1;
    ie_nxt      = int_en;
    restore_nxt = 1'b0;
    if (take_irq) begin
      push   = 1'b1;
      pc_nxt = VECTOR;
      ie_nxt = 1'b0;
    end else begin
      unique case (flow_op_e'(op))
        OP_JUMP: if (pass) pc_nxt = target;
        OP_CALL: if (pass) begin
          push   = 1'b1;
          pc_nxt = target;
        end
        OP_RET:  if (pass) begin
          pop    = 1'b1;
          pc_nxt = stack_top + 1'b1;
        end
        OP_RETI: begin
          pop         = 1'b1;
          pc_nxt      = stack_top;
          ie_nxt      = reti_ie;
          restore_nxt = 1'b1;
        end
        OP_IEN:  ie_nxt = 1'b1;
        OP_IDIS: ie_nxt = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc           <= '0;
      int_en       <= 1'b0;
      irq_ack      <= 1'b0;
      flag_restore <= 1'b0;
      restore_c    <= 1'b0;
      restore_z    <= 1'b0;
    end else begin
      pc           <= pc_nxt;
      int_en       <= ie_nxt;
      irq_ack      <= take_irq;
      flag_restore <= restore_nxt;
      if (take_irq) begin
        restore_c <= flag_c;
        restore_z <= flag_z;
      end
    end
  end
endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
  parameter int PC_W  = 10,
  parameter int DEPTH = 31,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      op,
  input logic            cond_en,
  input logic [PC_W-1:0] target,
  input logic            reti_ie,
  input logic            flag_c,
  input logic            flag_z,
  input logic            irq,
  input logic [PC_W-1:0] pc,
  input logic [PW-1:0]   tos,
  input logic [PC_W-1:0] stack_top,
  input logic            int_en,
  input logic            irq_ack,
  input logic            flag_restore,
  input logic            restore_c,
  input logic            restore_z
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (irq && int_en) |=> (pc == '1) && irq_ack && !int_en
      && restore_c == $past(flag_c) && restore_z == $past(flag_z)); // R8

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack); // R8

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd1 && !cond_en && !(irq && int_en)) |=> pc == $past(target)); // R1

  AST_CALL_PUSH: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2 && !cond_en && !(irq && int_en)) |=>
      (tos == (($past(tos) == LAST) ? '0 : $past(tos) + 1'b1))
      && stack_top == $past(pc) && pc == $past(target)); // R3

  AST_RETI_RESUME: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd4 && !(irq && int_en)) |=>
      pc == $past(stack_top) && flag_restore && int_en == $past(reti_ie)); // R6

  AST_IEN_ONLY: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd5 && !(irq && int_en)) |=>
      int_en && tos == $past(tos) && pc == $past(pc) + 1'b1); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (irq && !int_en) |=> !irq_ack); // R11
endmodule

bind flow_seq flow_seq_chk #(.PC_W(PC_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .op(op), .cond_en(cond_en), .target(target),
  .reti_ie(reti_ie), .flag_c(flag_c), .flag_z(flag_z), .irq(irq),
  .pc(pc), .tos(tos), .stack_top(stack_top), .int_en(int_en),
  .irq_ack(irq_ack), .flag_restore(flag_restore),
  .restore_c(restore_c), .restore_z(restore_z)
);

// File: tb/sim_flow_seq.sv
`timescale 1ns/1ps
module sim_flow_seq;
  localparam int PCM = 1024;
  localparam int DEP = 31;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op = '0;
  logic       cond_en = 1'b0;
  logic [1:0] cond_sel = '0;
  logic [9:0] target = '0;
  logic       reti_ie = 1'b0;
  logic       flag_c = 1'b0;
  logic       flag_z = 1'b0;
  logic       irq = 1'b0;
  logic [9:0] pc;
  logic [4:0] tos;
  logic [9:0] stack_top;
  logic       int_en, irq_ack, flag_restore, restore_c, restore_z;

  always #2.5 clk = ~clk;

  flow_seq u0 (
    .clk(clk), .rst(rst), .op(op), .cond_en(cond_en), .cond_sel(cond_sel),
    .target(target), .reti_ie(reti_ie), .flag_c(flag_c), .flag_z(flag_z),
    .irq(irq), .pc(pc), .tos(tos), .stack_top(stack_top), .int_en(int_en),
    .irq_ack(irq_ack), .flag_restore(flag_restore),
    .restore_c(restore_c), .restore_z(restore_z)
  );

  int runs = 0;
  int fails = 0;

  // behavioural reference state
  int mpc = 0, mtos = 0, mie = 0, mack = 0, mres = 0, msc = 0, msz = 0;
  int mstk [DEP];
  bit mval [DEP];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(pc == mpc, tag, "pc", pc, mpc);
    chk(tos == mtos, tag, "tos", tos, mtos);
    chk(int_en == mie, tag, "int_en", int_en, mie);
    chk(irq_ack == mack, tag, "irq_ack", irq_ack, mack);
    chk(flag_restore == mres, tag, "flag_restore", flag_restore, mres);
    chk(restore_c == msc && restore_z == msz, tag, "restore_cz",
        {restore_c, restore_z}, msc * 2 + msz);
    if (mval[mtos]) chk(stack_top == mstk[mtos], tag, "stack_top", stack_top, mstk[mtos]);
  endtask

  function automatic void mpush(input int v);
    mtos = (mtos + 1) % DEP;
    mstk[mtos] = v;
    mval[mtos] = 1'b1;
  endfunction

  function automatic void mpop();
    mtos = (mtos + DEP - 1) % DEP;
  endfunction

  function automatic void model(input int o, input int ce, input int cs, input int tg,
                                input int ri, input int fc, input int fz, input int iq);
    int ok;
    mack = 0;
    mres = 0;
    if (iq != 0 && mie != 0) begin
      mpush(mpc);
      msc = fc; msz = fz; mie = 0; mpc = PCM - 1; mack = 1;
      return;
    end
    case (cs)
      0: ok = fc;
      1: ok = !fc;
      2: ok = fz;
      default: ok = !fz;
    endcase
    if (ce == 0) ok = 1;
    case (o)
      1: mpc = ok ? tg : (mpc + 1) % PCM;
      2: if (ok) begin mpush(mpc); mpc = tg; end else mpc = (mpc + 1) % PCM;
      3: if (ok) begin mpc = (mstk[mtos] + 1) % PCM; mpop(); end
         else mpc = (mpc + 1) % PCM;
      4: begin mpc = mstk[mtos]; mpop(); mie = ri; mres = 1; end
      5: begin mie = 1; mpc = (mpc + 1) % PCM; end
      6: begin mie = 0; mpc = (mpc + 1) % PCM; end
      default: mpc = (mpc + 1) % PCM;
    endcase
  endfunction

  // compare the state produced by the previous edge, then present the next command
  task automatic cyc(input string tag, input int o, input int ce = 0, input int cs = 0,
                     input int tg = 0, input int ri = 0, input int fc = 0,
                     input int fz = 0, input int iq = 0);
    @(negedge clk);
    compare(tag);
    rst = 1'b0;
    op = 3'(o); cond_en = 1'(ce); cond_sel = 2'(cs); target = 10'(tg);
    reti_ie = 1'(ri); flag_c = 1'(fc); flag_z = 1'(fz); irq = 1'(iq);
    model(o, ce, cs, tg, ri, fc, fz, iq);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op = '0; irq = 1'b0;
    mpc = 0; mtos = 0; mie = 0; mack = 0; mres = 0; msc = 0; msz = 0;
  endtask

  initial begin
    int o;
    for (int i = 0; i < DEP; i++) begin mval[i] = 1'b0; mstk[i] = 0; end
    // R10: reset state seen at the first compare
    cyc("R10", 0);
    cyc("R2", 0);
    cyc("R2", 7);
    // R1: unconditional jump, then pc wrap at the top of the space
    cyc("R1", 1, 0, 0, 1023);
    cyc("R1", 0);
    cyc("R1", 1, 0, 0, 200);
    // R2: each condition with its flag set and clear
    for (int cs = 0; cs < 4; cs++) begin
      for (int f = 0; f < 2; f++) begin
        cyc("R2", 1, 1, cs, 300 + cs * 10 + f, 0, (cs < 2) ? f : 1 - f, (cs < 2) ? 1 - f : f);
      end
    end
    // R3/R4: nested calls and returns, conditional forms
    cyc("R3", 2, 0, 0, 40);
    cyc("R3", 2, 1, 2, 80, 0, 0, 1);
    cyc("R3", 2, 1, 3, 90, 0, 0, 1);
    cyc("R4", 3, 1, 1, 0, 0, 1, 0);
    cyc("R4", 3, 1, 0, 0, 0, 1, 0);
    cyc("R4", 3);
    // R7: enable and disable only touch the flag
    cyc("R7", 5);
    cyc("R7", 6);
    // R11: request ignored while disabled
    cyc("R11", 2, 0, 0, 500, 0, 1, 1, 1);
    cyc("R11", 1, 0, 0, 600, 0, 0, 0, 1);
    cyc("R7", 5);
    // R8: interrupt entry with C=1 Z=0, then flags change before the return
    cyc("R8", 1, 0, 0, 700, 0, 1, 0, 1);
    cyc("R8", 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R5", 0, 0, 0, 0, 0, 0, 1);
    // R5/R6: interrupt return re-enabling
    cyc("R5", 4, 0, 0, 0, 1, 0, 1);
    cyc("R6", 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R6", 4, 0, 0, 0, 0, 1, 1);
    cyc("R6", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R6", 0);
    // R9: 33 pushes then 34 pops around the 31-entry ring
    do_reset();
    for (int i = 0; i < 33; i++) cyc("R9", 2, 0, 0, 10 * i + 3);
    for (int i = 0; i < 34; i++) cyc("R9", 3);
    cyc("R9", 0);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      o = $urandom_range(0, 7);
      if ((o == 3 || o == 4) && !mval[mtos]) o = 2;
      cyc("R2", o, $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1023),
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
          ($urandom_range(0, 15) == 0) ? 1 : 0);
    end
    cyc("R2", 0);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    runs++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule